// File: doc/BRIEF.md
# Power-Down Sequencing Controller

This block decides when a clock generator's outputs may run, given one asynchronous, active-low power-down pin. It brings that pin into the reference-clock domain through a flop chain and then through a persistence filter. Once the request is accepted, the reference output is cut first. The other output enables drop on the next cycle, and one cycle after that the oscillator-run flag turns off the internal oscillator and VCO. The CPU-group and PCI-group hold inputs have no effect while the device is powered down.

When the pin returns high, the oscillator-run flag comes back on and a stabilization counter starts. Outputs are not released until that counter has expired. Each enable is then set only in a cycle where that output's clock is low, so the first high pulse on every output is a full one. The ready flag rises once every wanted output is enabled. The block comes out of reset in the powered-down state and takes the same exit path.

Top module: `pdn_seq_ctrl`

## Requirements
- R1: The pin passes through a two-flop synchronizer and a filter. A low level driven just after clock edge N first shows at the outputs after edge N+4, as the reference enable falling (FILT_CYC = 2).
- R2: A pin low lasting a single clock period changes no output.
- R3: On entry, `ref_en` falls one cycle before every other enable and before `ready`.
- R4: From entry edge N+5 onward, every enable and `ready` are 0.
- R5: `osc_on` falls one edge after the enables fall (edge N+6). On exit it rises four edges after the pin rises.
- R6: While the device is powered down, `cpu_hold_n` and `pci_hold_n` are ignored and all enables stay 0.
- R7: After the pin rises at edge M, enables stay 0 through edge M+4+WAIT_CYC. They rise at edge M+5+WAIT_CYC, and `ready` rises at M+6+WAIT_CYC.
- R8: An enable is set only at an edge where its clock-level input is 0. While any wanted output has its level high, that enable stays 0 and `ready` stays 0.
- R9: During reset, and for three edges after reset is released with the pin high, all outputs are 0. The exit then follows the timing of R7.
- R10: In normal operation, `cpu_hold_n` (or `pci_hold_n`) low clears its group's enables at the next edge. When the hold is released, each enable is set again at the first edge where its level is low.
- R11: A new power-down during the stabilization wait cancels that wait. All enables stay 0, and a full new wait starts from the next pin release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pdn_n_pin | input | 1 | Raw asynchronous power-down pin, low = power down |
| cpu_hold_n | input | 1 | Low stops the CPU clock group (normal operation only) |
| pci_hold_n | input | 1 | Low stops the PCI clock group (normal operation only) |
| cpu_lvl | input | CPU_W | Present level of each CPU clock |
| pci_lvl | input | PCI_W | Present level of each PCI clock |
| pcif_lvl | input | 1 | Present level of the free-running PCI clock |
| usb_lvl | input | 1 | Present level of the 48 MHz clock |
| ref_lvl | input | 1 | Present level of the reference clock output |
| cpu_en | output | CPU_W | Enable for each CPU clock output |
| pci_en | output | PCI_W | Enable for each PCI clock output |
| pcif_en | output | 1 | Enable for the free-running PCI clock |
| usb_en | output | 1 | Enable for the 48 MHz clock |
| ref_en | output | 1 | Enable for the reference clock output |
| osc_on | output | 1 | Keeps the internal oscillator and VCO running |
| ready | output | 1 | All wanted outputs are running |

## Verification
The pin reaches the reference enable four edges after it changes and the other enables five edges after. `osc_on` follows one edge later, and on exit the enables come back WAIT_CYC+5 edges after the pin rises. The hold inputs act on the very next edge. For each stimulus, the driver records the edge count at which it drove the inputs and queues the full output vector at exactly those offsets. The monitor samples between clock edges and compares whenever the count reaches the recorded edge. Held-high clock levels and a second power-down during the wait both move the due cycles, and the queued values then show whether outputs are held off.

// File: rtl/pdn_pkg.sv
package pdn_pkg;
   typedef enum logic [2:0] {
      PD_RUN  = 3'd0,
      PD_HALT = 3'd1,
      PD_OFF  = 3'd2,
      PD_WAIT = 3'd3,
      PD_REL  = 3'd4
   } pd_state_e;
endpackage

// File: rtl/pdn_sync.sv
module pdn_sync #(
   parameter int unsigned STAGES  = 2,
   parameter bit          RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/pdn_filter.sv
module pdn_filter #(
   parameter int unsigned FILT = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_s,
   output logic pd_det
);
   generate
      if (FILT == 1) begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pd_det <= 1'b1;
            else        pd_det <= ~pin_s;
         end
      end else begin : g_count
         localparam int unsigned CW = $clog2(FILT);
         logic [CW-1:0] run_len;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               run_len <= '0;
               pd_det  <= 1'b1;
            end else if (pin_s) begin
               run_len <= '0;
               pd_det  <= 1'b0;
            end else if (run_len == CW'(FILT - 1)) begin
               pd_det  <= 1'b1;
            end else begin
               run_len <= run_len + CW'(1);
            end
         end
      end
   endgenerate
endmodule

// File: rtl/pdn_fsm.sv
module pdn_fsm
   import pdn_pkg::*;
#(
   parameter int unsigned WAIT_CYC = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pd_det,
   input  logic all_up,
   output logic rel_ok,
   output logic osc_on,
   output logic ready
);
   localparam int unsigned WCW = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;

   pd_state_e      st, st_nx;
   logic [WCW-1:0] wcnt, wcnt_nx;

   always_comb begin
      st_nx   = st;
      wcnt_nx = wcnt;
      unique case (st)
         PD_RUN:  if (pd_det) st_nx = PD_HALT;
         PD_HALT: st_nx = PD_OFF;
         PD_OFF:  if (!pd_det) begin
                     st_nx   = PD_WAIT;
                     wcnt_nx = '0;
                  end
         PD_WAIT: if (pd_det)                          st_nx = PD_HALT;
                  else if (wcnt == WCW'(WAIT_CYC - 1)) st_nx = PD_REL;
                  else                                 wcnt_nx = wcnt + WCW'(1);
         PD_REL:  if (pd_det)      st_nx = PD_HALT;
                  else if (all_up) st_nx = PD_RUN;
         default: st_nx = PD_OFF;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= PD_OFF;
         wcnt <= '0;
      end else begin
         st   <= st_nx;
         wcnt <= wcnt_nx;
      end
   end

   assign rel_ok = (st == PD_RUN) || (st == PD_REL);
   assign osc_on = (st != PD_OFF);
   assign ready  = (st == PD_RUN);
endmodule

// File: rtl/pdn_gate.sv
module pdn_gate #(
   parameter int unsigned N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] want,
   input  logic [N-1:0] lvl,
   output logic [N-1:0] en
);
   generate
      for (genvar i = 0; i < N; i++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       en[i] <= 1'b0;
            else if (!want[i]) en[i] <= 1'b0;
            else if (!lvl[i])  en[i] <= 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/pdn_seq_ctrl.sv
module pdn_seq_ctrl #(
   parameter int unsigned CPU_W       = 2,
   parameter int unsigned PCI_W       = 5,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned FILT_CYC    = 2,
   parameter int unsigned WAIT_CYC    = 42000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pdn_n_pin,
   input  logic             cpu_hold_n,
   input  logic             pci_hold_n,
   input  logic [CPU_W-1:0] cpu_lvl,
   input  logic [PCI_W-1:0] pci_lvl,
   input  logic             pcif_lvl,
   input  logic             usb_lvl,
   input  logic             ref_lvl,
   output logic [CPU_W-1:0] cpu_en,
   output logic [PCI_W-1:0] pci_en,
   output logic             pcif_en,
   output logic             usb_en,
   output logic             ref_en,
   output logic             osc_on,
   output logic             ready
);
   localparam int unsigned N_OUT    = CPU_W + PCI_W + 3;
   localparam int unsigned IDX_PCIF = CPU_W + PCI_W;
   localparam int unsigned IDX_USB  = IDX_PCIF + 1;
   localparam int unsigned IDX_REF  = IDX_PCIF + 2;

   generate
      if (CPU_W < 1 || PCI_W < 1) begin : g_bad_w
         $error("pdn_seq_ctrl: each clock group needs at least one output");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("pdn_seq_ctrl: SYNC_STAGES must be 2 or more");
      end
      if (FILT_CYC < 1) begin : g_bad_filt
         $error("pdn_seq_ctrl: FILT_CYC must be 1 or more");
      end
      if (WAIT_CYC < 1) begin : g_bad_wait
         $error("pdn_seq_ctrl: WAIT_CYC must be 1 or more");
      end
   endgenerate

   logic             pin_s, pd_det, rel_ok, all_up;
   logic [N_OUT-1:0] lvl_all, want, gate_en;

   pdn_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pdn_n_pin), .q(pin_s)
   );

   pdn_filter #(.FILT(FILT_CYC)) u_filt (
      .clk(clk), .rst_n(rst_n), .pin_s(pin_s), .pd_det(pd_det)
   );

   assign lvl_all = {ref_lvl, usb_lvl, pcif_lvl, pci_lvl, cpu_lvl};

   generate
      for (genvar i = 0; i < N_OUT; i++) begin : g_want
         if (i < CPU_W) begin : g_cpu
            assign want[i] = rel_ok & ~pd_det & cpu_hold_n;
         end else if (i < IDX_PCIF) begin : g_pci
            assign want[i] = rel_ok & ~pd_det & pci_hold_n;
         end else begin : g_free
            assign want[i] = rel_ok & ~pd_det;
         end
      end
   endgenerate

   pdn_gate #(.N(N_OUT)) u_gate (
      .clk(clk), .rst_n(rst_n), .want(want), .lvl(lvl_all), .en(gate_en)
   );

   assign all_up = &(gate_en | ~want);

   pdn_fsm #(.WAIT_CYC(WAIT_CYC)) u_fsm (
      .clk(clk), .rst_n(rst_n), .pd_det(pd_det), .all_up(all_up),
      .rel_ok(rel_ok), .osc_on(osc_on), .ready(ready)
   );

   assign cpu_en  = gate_en[CPU_W-1:0];
   assign pci_en  = gate_en[IDX_PCIF-1:CPU_W];
   assign pcif_en = gate_en[IDX_PCIF];
   assign usb_en  = gate_en[IDX_USB];
   assign ref_en  = gate_en[IDX_REF] & ~pd_det;
endmodule

// File: rtl/pdn_seq_chk.sv
module pdn_seq_chk #(
   parameter int unsigned CPU_W    = 2,
   parameter int unsigned PCI_W    = 5,
   parameter int unsigned WAIT_CYC = 16
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic [CPU_W+PCI_W+2:0]   en_q,
   input logic [CPU_W+PCI_W+2:0]   lvl,
   input logic                     osc_on,
   input logic                     ready,
   input logic                     ref_en,
   input logic                     pcif_en,
   input logic                     usb_en
);
   localparam int unsigned N_OUT = CPU_W + PCI_W + 3;

   logic [31:0] on_len;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      on_len <= '0;
      else if (!osc_on)                on_len <= '0;
      else if (on_len < 32'(WAIT_CYC)) on_len <= on_len + 32'd1;
   end

   p_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !osc_on |-> (en_q == '0) && !ready);

   p_ref_leads_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ready) |-> !ref_en && $past(!ref_en));

   p_osc_after_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(osc_on) |-> $past(en_q == '0));

   p_wait_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> on_len >= 32'(WAIT_CYC));

   p_ready_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> pcif_en && usb_en && ref_en);

   generate
      for (genvar i = 0; i < N_OUT; i++) begin : g_runt
         p_no_runt_r8: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(en_q[i]) |-> !$past(lvl[i]));
      end
   endgenerate
endmodule

bind pdn_seq_ctrl pdn_seq_chk #(
   .CPU_W(CPU_W), .PCI_W(PCI_W), .WAIT_CYC(WAIT_CYC)
) u_chk (
   .clk(clk), .rst_n(rst_n), .en_q(gate_en), .lvl(lvl_all),
   .osc_on(osc_on), .ready(ready), .ref_en(ref_en),
   .pcif_en(pcif_en), .usb_en(usb_en)
);

// File: tb/sim_pdn_seq_ctrl.sv
`timescale 1ns/1ps
module sim_pdn_seq_ctrl;
   localparam int unsigned W = 20;

   logic       clk = 1'b0;
   logic       rst_n, pin, cpu_hold_n, pci_hold_n;
   logic [1:0] cpu_lvl;
   logic [4:0] pci_lvl;
   logic       pcif_lvl, usb_lvl, ref_lvl;
   logic [1:0] cpu_en;
   logic [4:0] pci_en;
   logic       pcif_en, usb_en, ref_en, osc_on, ready;

   always #4 clk = ~clk;

   pdn_seq_ctrl #(.CPU_W(2), .PCI_W(5), .SYNC_STAGES(2), .FILT_CYC(2), .WAIT_CYC(W)) u0 (
      .clk(clk), .rst_n(rst_n), .pdn_n_pin(pin),
      .cpu_hold_n(cpu_hold_n), .pci_hold_n(pci_hold_n),
      .cpu_lvl(cpu_lvl), .pci_lvl(pci_lvl), .pcif_lvl(pcif_lvl),
      .usb_lvl(usb_lvl), .ref_lvl(ref_lvl),
      .cpu_en(cpu_en), .pci_en(pci_en), .pcif_en(pcif_en),
      .usb_en(usb_en), .ref_en(ref_en), .osc_on(osc_on), .ready(ready)
   );

   // observed vector: ready[11] osc_on[10] ref[9] usb[8] pcif[7] pci[6:2] cpu[1:0]
   wire [11:0] obs = {ready, osc_on, ref_en, usb_en, pcif_en, pci_en, cpu_en};

   typedef struct {
      int unsigned at;
      logic [11:0] val;
      string       req;
   } exp_t;

   exp_t        sb[$];
   int unsigned cyc = 0;
   int unsigned n_chk = 0, n_bad = 0;
   bit          done = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic expect_at(int unsigned at, logic [11:0] v, string req);
      exp_t e;
      e.at = at; e.val = v; e.req = req;
      sb.push_back(e);
   endtask

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   always @(negedge clk) begin
      exp_t e;
      #1;
      while (sb.size() > 0 && sb[0].at <= cyc) begin
         e = sb.pop_front();
         n_chk++;
         if (obs !== e.val) begin
            n_bad++;
            $display("FAIL %s at edge %0d: got %h expected %h", e.req, cyc, obs, e.val);
         end
      end
   end

   initial begin
      repeat (6000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int unsigned b, a, c;
      rst_n = 1'b0; pin = 1'b1; cpu_hold_n = 1'b1; pci_hold_n = 1'b1;
      cpu_lvl = '0; pci_lvl = '0; pcif_lvl = 1'b0; usb_lvl = 1'b0; ref_lvl = 1'b0;
      step(2);
      expect_at(cyc + 1, 12'h000, "R9 in reset");
      step(2);

      // R9 / R7: exit from reset
      rst_n = 1'b1; b = cyc;
      expect_at(b + 3, 12'h000, "R9 still down");
      expect_at(b + 4, 12'h400, "R5 osc on at wait start");
      expect_at(b + 4 + W, 12'h400, "R7 wait not expired");
      expect_at(b + 5 + W, 12'h7FF, "R7 enables up");
      expect_at(b + 6 + W, 12'hFFF, "R7 ready");
      step(W + 8);

      // R2: single-cycle glitch
      pin = 1'b0; b = cyc;
      for (int k = 1; k <= 7; k++) expect_at(b + k, 12'hFFF, "R2 glitch ignored");
      step(1); pin = 1'b1;
      step(8);

      // R10 / R8: group holds in normal operation
      cpu_hold_n = 1'b0; b = cyc;
      expect_at(b + 1, 12'hFFC, "R10 cpu stop");
      step(2);
      cpu_lvl = 2'b11; cpu_hold_n = 1'b1; b = cyc;
      expect_at(b + 1, 12'hFFC, "R8 cpu held while high");
      expect_at(b + 2, 12'hFFC, "R8 cpu held while high");
      step(3);
      cpu_lvl = 2'b00; b = cyc;
      expect_at(b + 1, 12'hFFF, "R10 cpu restart");
      step(2);
      pci_hold_n = 1'b0; b = cyc;
      expect_at(b + 1, 12'hF83, "R10 pci stop");
      step(2);
      pci_hold_n = 1'b1; b = cyc;
      expect_at(b + 1, 12'hFFF, "R10 pci restart");
      step(2);

      // R1 / R3 / R4 / R5: entry
      pin = 1'b0; b = cyc;
      expect_at(b + 3, 12'hFFF, "R1 not yet seen");
      expect_at(b + 4, 12'hDFF, "R3 ref first");
      expect_at(b + 5, 12'h400, "R4 all low");
      expect_at(b + 6, 12'h000, "R5 osc off");
      step(8);

      // R6: holds ignored while down
      cpu_hold_n = 1'b0; pci_hold_n = 1'b0; b = cyc;
      expect_at(b + 1, 12'h000, "R6 holds low ignored");
      expect_at(b + 2, 12'h000, "R6 holds low ignored");
      step(2);
      cpu_hold_n = 1'b1; pci_hold_n = 1'b1; b = cyc;
      expect_at(b + 1, 12'h000, "R6 holds high ignored");
      expect_at(b + 2, 12'h000, "R6 holds high ignored");
      step(3);

      // R7 / R8: exit with reference clock level held high
      ref_lvl = 1'b1; pin = 1'b1; b = cyc;
      expect_at(b + 4, 12'h400, "R5 osc on");
      expect_at(b + 4 + W, 12'h400, "R7 wait not expired");
      expect_at(b + 5 + W, 12'h5FF, "R8 ref held off");
      expect_at(b + 6 + W, 12'h5FF, "R8 ready held off");
      step(W + 7);
      ref_lvl = 1'b0; b = cyc;
      expect_at(b + 1, 12'h7FF, "R8 ref released");
      expect_at(b + 2, 12'hFFF, "R8 ready");
      step(3);

      // R11: power-down during the wait
      pin = 1'b0;
      step(8);
      pin = 1'b1; a = cyc;
      expect_at(a + 4, 12'h400, "R11 wait running");
      step(10);
      pin = 1'b0; b = cyc;
      expect_at(b + 5, 12'h400, "R11 halting");
      expect_at(b + 6, 12'h000, "R11 wait cancelled");
      step(10);
      pin = 1'b1; c = cyc;
      expect_at(c + 4, 12'h400, "R11 new wait");
      expect_at(c + 5, 12'h400, "R11 old count void");
      expect_at(c + 4 + W, 12'h400, "R11 full new wait");
      expect_at(c + 5 + W, 12'h7FF, "R11 enables up");
      expect_at(c + 6 + W, 12'hFFF, "R11 ready");
      step(W + 10);

      while (sb.size() > 0) step(1);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule